// File: doc/BRIEF.md
# Speculative Read/Write-Set Tracking Cache Tags

This block holds the tag and state for a private, set-associative L1 data cache. Each line carries two extra flags: one marking membership in the read set of the running speculative chunk, and one marking membership in its write set. Core accesses flagged as speculative set these flags. Incoming coherence snoops are compared against them, and a conflict is reported in the same cycle as the lookup. A single-cycle commit clears every flag. A single-cycle abort drops every line in the write set and clears the rest of the flags, so the chunk becomes visible atomically or not at all.

Before a speculative store first modifies a line that is dirty but not yet in the write set, the block writes that line back. This keeps a pre-speculation copy below the cache for recovery. Misses pick a victim: the lowest invalid way if there is one, otherwise a per-set round-robin pointer that advances on every fill. A dirty, non-speculative victim is written back before the fill. A victim that belongs to the read or write set is never evicted. Instead, the block raises a forced-commit request and stalls the access until the core commits or aborts. Data storage, lower levels and the coherence protocol sit outside the block, behind a simple writeback port and a fill port, each with a one-cycle acknowledge.

The core holds a request stable until `req_done_o` is high in a cycle. Addresses are line addresses: the low `log2(SETS)` bits select the set and the rest form the tag.

Top module: `spec_set_cache`

## Requirements
- R1: After reset every line is invalid and no output is active. The first access to any address requests a fill of that address, and no snoop reports a conflict.
- R2: A speculative load sets the line's read flag, whether it hits or completes after a fill. A later write snoop to that line conflicts, and a read snoop does not.
- R3: A speculative store sets the line's write flag, including after a miss fill. Any snoop to the line then conflicts.
- R4: A speculative store that hits a dirty line whose write flag is clear first writes back that line's address. It completes only after `wb_ack_i`, and then sets the write flag.
- R5: A store that hits a line whose write flag is set completes in the cycle it is presented, with no writeback and no fill.
- R6: `violation_o` is combinational from the snoop inputs and rises in the snoop cycle. It is accompanied by the set index (address low bits) and the way of the conflicting line. A read snoop to a line that is only in the read set does not conflict.
- R7: `commit_i` clears every read and write flag in one cycle. Lines stay valid and keep their dirty state.
- R8: `abort_i` invalidates every line whose write flag is set and clears all flags in one cycle. Lines outside the write set stay valid.
- R9: If the chosen victim has either flag set, `force_commit_o` is raised and the request stalls with no writeback and no fill. A line with a flag set is never overwritten by a fill.
- R10: Victim choice is the lowest-numbered invalid way, otherwise a per-set round-robin pointer that starts at way 0 and advances on each fill. A dirty victim is written back (victim address) before the fill, and the fill address is the request address.
- R11: A commit or abort in the same cycle as a request takes priority, and the request does not complete in that cycle.
- R12: Non-speculative loads and stores set no flags. A non-speculative store marks the line dirty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Core access present, held until done |
| req_write_i | input | 1 | Access is a store |
| req_spec_i | input | 1 | Access belongs to the speculative chunk |
| req_addr_i | input | ADDR_W | Line address of the access |
| req_done_o | output | 1 | Access completes this cycle |
| force_commit_o | output | 1 | Victim is speculative; commit or abort needed |
| commit_i | input | 1 | Clear all speculative flags |
| abort_i | input | 1 | Drop write-set lines, clear all flags |
| wb_valid_o | output | 1 | Writeback request |
| wb_addr_o | output | ADDR_W | Line address to write back |
| wb_ack_i | input | 1 | Writeback accepted this cycle |
| fill_req_o | output | 1 | Fill request |
| fill_addr_o | output | ADDR_W | Line address to fill |
| fill_ack_i | input | 1 | Fill returned this cycle |
| snp_valid_i | input | 1 | Coherence snoop present |
| snp_write_i | input | 1 | Snoop requests write ownership |
| snp_addr_i | input | ADDR_W | Snoop line address |
| violation_o | output | 1 | Snoop conflicts with the speculative sets |
| violation_set_o | output | log2(SETS) | Set of the conflicting line |
| violation_way_o | output | log2(WAYS) | Way of the conflicting line |

## Verification
Snoop conflicts and hit completions are combinational. They are sampled 2 ns after the falling edge on which the inputs were driven, before the next rising edge. Flag changes from an access, commit or abort take effect at the next rising edge, so they are observed through a snoop or an access on a later cycle. A writeback or fill request appears in the cycle after the miss or recovery decision. The bench acknowledges it in that same cycle. The retried lookup then completes one cycle after the acknowledge, and the access task counts requests cycle by cycle until `req_done_o` or `force_commit_o` is seen.

// File: rtl/spc_pkg.sv
package spc_pkg;
  typedef struct packed {
    logic valid;
    logic dirty;
    logic sr;   // read-set member
    logic sw;   // write-set member
  } line_flags_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WB_REC,
    ST_WB_EVICT,
    ST_FILL
  } ctrl_state_t;
endpackage

// File: rtl/spc_tag_array.sv
module spc_tag_array
  import spc_pkg::*;
#(
  parameter int SETS  = 8,
  parameter int WAYS  = 2,
  parameter int TAG_W = 9
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             commit_i,
  input  logic                             abort_i,
  input  logic                             wr_en_i,
  input  logic                             fill_i,
  input  logic [$clog2(SETS)-1:0]          wr_idx_i,
  input  logic [$clog2(WAYS)-1:0]          wr_way_i,
  input  logic [TAG_W-1:0]                 wr_tag_i,
  input  line_flags_t                      wr_flags_i,
  input  logic [$clog2(SETS)-1:0]          rd_idx_i,
  output logic [WAYS-1:0][TAG_W-1:0]       rd_tags_o,
  output line_flags_t [WAYS-1:0]           rd_flags_o,
  output logic [$clog2(WAYS)-1:0]          rd_rr_o,
  input  logic [$clog2(SETS)-1:0]          snp_idx_i,
  output logic [WAYS-1:0][TAG_W-1:0]       snp_tags_o,
  output line_flags_t [WAYS-1:0]           snp_flags_o
);
  localparam int IDX_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);

  logic [WAYS-1:0][TAG_W-1:0] set_tags  [SETS];
  line_flags_t [WAYS-1:0]     set_flags [SETS];
  logic [WAY_W-1:0]           set_rr    [SETS];

  for (genvar s = 0; s < SETS; s++) begin : g_set
    logic [WAYS-1:0][TAG_W-1:0] tags_row;
    line_flags_t [WAYS-1:0]     flags_row;
    logic [WAY_W-1:0]           rr_q;
    logic                       set_hit;

    assign set_hit = wr_en_i && (wr_idx_i == IDX_W'(s));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                rr_q <= '0;
      else if (set_hit && fill_i) rr_q <= (rr_q == WAY_W'(WAYS - 1)) ? '0 : rr_q + 1'b1;
    end

    for (genvar w = 0; w < WAYS; w++) begin : g_way
      logic [TAG_W-1:0] tag_q;
      line_flags_t      flags_q, flags_d, base;
      logic             sel;

      assign sel = set_hit && (wr_way_i == WAY_W'(w));

      // write first, flash ops override the speculative bits
      always_comb begin
        base    = sel ? wr_flags_i : flags_q;
        flags_d = base;
        if (abort_i) begin
          if (base.sw) begin
            flags_d.valid = 1'b0;
            flags_d.dirty = 1'b0;
          end
          flags_d.sr = 1'b0;
          flags_d.sw = 1'b0;
        end else if (commit_i) begin
          flags_d.sr = 1'b0;
          flags_d.sw = 1'b0;
        end
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          flags_q <= '0;
          tag_q   <= '0;
        end else begin
          flags_q <= flags_d;
          if (sel && fill_i) tag_q <= wr_tag_i;
        end
      end

      assign tags_row[w]  = tag_q;
      assign flags_row[w] = flags_q;

      p_commit_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        commit_i && !abort_i |=> !flags_q.sr && !flags_q.sw);
      p_abort_drops_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        abort_i && flags_q.sw |=> !flags_q.valid);
      p_recover_first_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sel && wr_flags_i.sw && !flags_q.sw && !abort_i && !commit_i |-> !flags_q.dirty);
      p_no_spec_evict_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sel && fill_i |-> !flags_q.sr && !flags_q.sw);
    end

    assign set_tags[s]  = tags_row;
    assign set_flags[s] = flags_row;
    assign set_rr[s]    = rr_q;
  end

  assign rd_tags_o   = set_tags[rd_idx_i];
  assign rd_flags_o  = set_flags[rd_idx_i];
  assign rd_rr_o     = set_rr[rd_idx_i];
  assign snp_tags_o  = set_tags[snp_idx_i];
  assign snp_flags_o = set_flags[snp_idx_i];
endmodule

// File: rtl/spc_match.sv
module spc_match
  import spc_pkg::*;
#(
  parameter int WAYS  = 2,
  parameter int TAG_W = 9
) (
  input  logic [WAYS-1:0][TAG_W-1:0] tags_i,
  input  line_flags_t [WAYS-1:0]     flags_i,
  input  logic [TAG_W-1:0]           tag_i,
  output logic                       hit_o,
  output logic [$clog2(WAYS)-1:0]    way_o,
  output line_flags_t                flags_o
);
  localparam int WAY_W = $clog2(WAYS);

  always_comb begin
    hit_o   = 1'b0;
    way_o   = '0;
    flags_o = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (!hit_o && flags_i[w].valid && tags_i[w] == tag_i) begin
        hit_o   = 1'b1;
        way_o   = WAY_W'(w);
        flags_o = flags_i[w];
      end
    end
  end
endmodule

// File: rtl/spc_ctrl.sv
module spc_ctrl
  import spc_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int SETS   = 8,
  parameter int WAYS   = 2
) (
  input  logic                                          clk_i,
  input  logic                                          rst_ni,
  input  logic                                          req_valid_i,
  input  logic                                          req_write_i,
  input  logic                                          req_spec_i,
  input  logic [ADDR_W-1:0]                             req_addr_i,
  input  logic                                          commit_i,
  input  logic                                          abort_i,
  input  logic                                          hit_i,
  input  logic [$clog2(WAYS)-1:0]                       hit_way_i,
  input  line_flags_t                                   hit_flags_i,
  input  logic [WAYS-1:0][ADDR_W-$clog2(SETS)-1:0]      set_tags_i,
  input  line_flags_t [WAYS-1:0]                        set_flags_i,
  input  logic [$clog2(WAYS)-1:0]                       rr_i,
  input  logic                                          wb_ack_i,
  input  logic                                          fill_ack_i,
  output logic                                          done_o,
  output logic                                          force_commit_o,
  output logic                                          wb_valid_o,
  output logic [ADDR_W-1:0]                             wb_addr_o,
  output logic                                          fill_req_o,
  output logic [ADDR_W-1:0]                             fill_addr_o,
  output logic                                          wr_en_o,
  output logic                                          fill_o,
  output logic [$clog2(SETS)-1:0]                       wr_idx_o,
  output logic [$clog2(WAYS)-1:0]                       wr_way_o,
  output logic [ADDR_W-$clog2(SETS)-1:0]                wr_tag_o,
  output line_flags_t                                   wr_flags_o
);
  localparam int IDX_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);

  ctrl_state_t       st_q, st_d;
  logic [WAY_W-1:0]  way_q, way_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [WAY_W-1:0]  vic_way;
  logic              vic_free;
  line_flags_t       vic_flags;

  always_comb begin
    vic_way  = rr_i;
    vic_free = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      if (!vic_free && !set_flags_i[w].valid) begin
        vic_way  = WAY_W'(w);
        vic_free = 1'b1;
      end
    end
    vic_flags = set_flags_i[vic_way];
  end

  always_comb begin
    st_d           = st_q;
    way_d          = way_q;
    addr_d         = addr_q;
    done_o         = 1'b0;
    force_commit_o = 1'b0;
    wb_valid_o     = 1'b0;
    fill_req_o     = 1'b0;
    wb_addr_o      = addr_q;
    fill_addr_o    = addr_q;
    wr_en_o        = 1'b0;
    fill_o         = 1'b0;
    wr_way_o       = hit_way_i;
    wr_flags_o     = hit_flags_i;
    unique case (st_q)
      ST_IDLE: begin
        if (req_valid_i && !commit_i && !abort_i) begin
          if (hit_i) begin
            if (!req_write_i) begin
              done_o = 1'b1;
              if (req_spec_i) begin
                wr_en_o       = 1'b1;
                wr_flags_o.sr = 1'b1;
              end
            end else if (req_spec_i && hit_flags_i.dirty && !hit_flags_i.sw) begin
              st_d   = ST_WB_REC;   // save pre-speculation copy first
              way_d  = hit_way_i;
              addr_d = req_addr_i;
            end else begin
              done_o           = 1'b1;
              wr_en_o          = 1'b1;
              wr_flags_o.dirty = 1'b1;
              wr_flags_o.sw    = hit_flags_i.sw | req_spec_i;
            end
          end else if (vic_flags.valid && (vic_flags.sr || vic_flags.sw)) begin
            force_commit_o = 1'b1;
          end else if (vic_flags.valid && vic_flags.dirty) begin
            st_d   = ST_WB_EVICT;
            way_d  = vic_way;
            addr_d = {set_tags_i[vic_way], req_addr_i[IDX_W-1:0]};
          end else begin
            st_d   = ST_FILL;
            way_d  = vic_way;
            addr_d = req_addr_i;
          end
        end
      end
      ST_WB_REC: begin
        wb_valid_o = 1'b1;
        if (wb_ack_i) begin
          wr_en_o          = 1'b1;
          wr_way_o         = way_q;
          wr_flags_o       = set_flags_i[way_q];
          wr_flags_o.dirty = 1'b0;
          st_d             = ST_IDLE;
        end
      end
      ST_WB_EVICT: begin
        wb_valid_o = 1'b1;
        if (wb_ack_i) begin
          wr_en_o    = 1'b1;
          wr_way_o   = way_q;
          wr_flags_o = '0;
          st_d       = ST_IDLE;
        end
      end
      ST_FILL: begin
        fill_req_o = 1'b1;
        if (fill_ack_i) begin
          wr_en_o    = 1'b1;
          fill_o     = 1'b1;
          wr_way_o   = way_q;
          wr_flags_o = line_flags_t'{valid: 1'b1, dirty: 1'b0, sr: 1'b0, sw: 1'b0};
          st_d       = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign wr_idx_o = (st_q == ST_IDLE) ? req_addr_i[IDX_W-1:0] : addr_q[IDX_W-1:0];
  assign wr_tag_o = addr_q[ADDR_W-1:IDX_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      way_q  <= '0;
      addr_q <= '0;
    end else begin
      st_q   <= st_d;
      way_q  <= way_d;
      addr_q <= addr_d;
    end
  end

  p_flash_first_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i || abort_i) |-> !done_o);
  p_wb_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o && !wb_ack_i |=> wb_valid_o && $stable(wb_addr_o));
  p_fill_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_req_o && !fill_ack_i |=> fill_req_o && $stable(fill_addr_o));
endmodule

// File: rtl/spec_set_cache.sv
module spec_set_cache
  import spc_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int SETS   = 8,
  parameter int WAYS   = 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      req_valid_i,
  input  logic                      req_write_i,
  input  logic                      req_spec_i,
  input  logic [ADDR_W-1:0]         req_addr_i,
  output logic                      req_done_o,
  output logic                      force_commit_o,
  input  logic                      commit_i,
  input  logic                      abort_i,
  output logic                      wb_valid_o,
  output logic [ADDR_W-1:0]         wb_addr_o,
  input  logic                      wb_ack_i,
  output logic                      fill_req_o,
  output logic [ADDR_W-1:0]         fill_addr_o,
  input  logic                      fill_ack_i,
  input  logic                      snp_valid_i,
  input  logic                      snp_write_i,
  input  logic [ADDR_W-1:0]         snp_addr_i,
  output logic                      violation_o,
  output logic [$clog2(SETS)-1:0]   violation_set_o,
  output logic [$clog2(WAYS)-1:0]   violation_way_o
);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam int WAY_W = $clog2(WAYS);

  logic [WAYS-1:0][TAG_W-1:0] rd_tags, snp_tags;
  line_flags_t [WAYS-1:0]     rd_flags, snp_flags;
  logic [WAY_W-1:0]           rd_rr, core_way, snp_way, wr_way;
  logic                       core_hit, snp_hit, wr_en, wr_fill;
  line_flags_t                core_flags, snp_line, wr_flags;
  logic [IDX_W-1:0]           wr_idx;
  logic [TAG_W-1:0]           wr_tag;

  spc_tag_array #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_array (
    .clk_i, .rst_ni, .commit_i, .abort_i,
    .wr_en_i    (wr_en),
    .fill_i     (wr_fill),
    .wr_idx_i   (wr_idx),
    .wr_way_i   (wr_way),
    .wr_tag_i   (wr_tag),
    .wr_flags_i (wr_flags),
    .rd_idx_i   (req_addr_i[IDX_W-1:0]),
    .rd_tags_o  (rd_tags),
    .rd_flags_o (rd_flags),
    .rd_rr_o    (rd_rr),
    .snp_idx_i  (snp_addr_i[IDX_W-1:0]),
    .snp_tags_o (snp_tags),
    .snp_flags_o(snp_flags)
  );

  spc_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_core_match (
    .tags_i (rd_tags),
    .flags_i(rd_flags),
    .tag_i  (req_addr_i[ADDR_W-1:IDX_W]),
    .hit_o  (core_hit),
    .way_o  (core_way),
    .flags_o(core_flags)
  );

  spc_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_snp_match (
    .tags_i (snp_tags),
    .flags_i(snp_flags),
    .tag_i  (snp_addr_i[ADDR_W-1:IDX_W]),
    .hit_o  (snp_hit),
    .way_o  (snp_way),
    .flags_o(snp_line)
  );

  spc_ctrl #(.ADDR_W(ADDR_W), .SETS(SETS), .WAYS(WAYS)) u_ctrl (
    .clk_i, .rst_ni, .req_valid_i, .req_write_i, .req_spec_i, .req_addr_i,
    .commit_i, .abort_i,
    .hit_i         (core_hit),
    .hit_way_i     (core_way),
    .hit_flags_i   (core_flags),
    .set_tags_i    (rd_tags),
    .set_flags_i   (rd_flags),
    .rr_i          (rd_rr),
    .wb_ack_i, .fill_ack_i,
    .done_o        (req_done_o),
    .force_commit_o, .wb_valid_o, .wb_addr_o, .fill_req_o, .fill_addr_o,
    .wr_en_o       (wr_en),
    .fill_o        (wr_fill),
    .wr_idx_o      (wr_idx),
    .wr_way_o      (wr_way),
    .wr_tag_o      (wr_tag),
    .wr_flags_o    (wr_flags)
  );

  // write-set line conflicts with any snoop, read-set line only with a write snoop
  assign violation_o     = snp_valid_i && snp_hit && (snp_line.sw || (snp_write_i && snp_line.sr));
  assign violation_set_o = snp_addr_i[IDX_W-1:0];
  assign violation_way_o = snp_way;

  p_conflict_live_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    violation_o |-> snp_line.valid && (snp_line.sr || snp_line.sw));
  p_done_on_hit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_done_o |-> core_hit && req_valid_i);
  p_force_stalls_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_commit_o |-> !req_done_o && !core_hit);
endmodule

// File: tb/spec_set_cache_bench.sv
module spec_set_cache_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid = 0, req_write = 0, req_spec = 0;
  logic [11:0] req_addr = '0;
  logic        commit = 0, abort = 0, wb_ack = 0, fill_ack = 0;
  logic        snp_valid = 0, snp_write = 0;
  logic [11:0] snp_addr = '0;
  logic        req_done, force_commit, wb_valid, fill_req, violation;
  logic [11:0] wb_addr, fill_addr;
  logic [2:0]  viol_set;
  logic        viol_way;

  int n_checks = 0;
  int n_fail   = 0;

  always #10 clk = ~clk;

  spec_set_cache u_spec_set_cache (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid), .req_write_i(req_write), .req_spec_i(req_spec), .req_addr_i(req_addr),
    .req_done_o(req_done), .force_commit_o(force_commit),
    .commit_i(commit), .abort_i(abort),
    .wb_valid_o(wb_valid), .wb_addr_o(wb_addr), .wb_ack_i(wb_ack),
    .fill_req_o(fill_req), .fill_addr_o(fill_addr), .fill_ack_i(fill_ack),
    .snp_valid_i(snp_valid), .snp_write_i(snp_write), .snp_addr_i(snp_addr),
    .violation_o(violation), .violation_set_o(viol_set), .violation_way_o(viol_way)
  );

  typedef struct packed {
    logic [2:0]  kind;   // 0 access, 1 snoop read, 2 snoop write, 3 commit, 4 abort
    logic [11:0] addr;
    logic        wr;
    logic        spec;
    logic [1:0]  e_wb;
    logic [1:0]  e_fill;
    logic        e_force;
    logic        e_viol;
    logic [2:0]  e_set;
    logic        e_way;
    logic [11:0] e_wba;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 12'h010, 1'b0, 1'b0, 2'd0, 2'd1, 1'b0, 1'b0, 3'd0, 1'b0, 12'h000, 4'd1},  // R1 empty: fill
    '{3'd2, 12'h010, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 3'd0, 1'b0, 12'h000, 4'd12}, // R12 plain load no flag
    '{3'd0, 12'h010, 1'b1, 1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 3'd0, 1'b0, 12'h000, 4'd12}, // R12 plain store dirty
    '{3'd0, 12'h010, 1'b1, 1'b1, 2'd1, 2'd0, 1'b0, 1'b0, 3'd0, 1'b0, 12'h010, 4'd4},  // R4 recovery wb
    '{3'd0, 12'h010, 1'b1, 1'b1, 2'd0, 2'd0, 1'b0, 1'b0, 3'd0, 1'b0, 12'h000, 4'd5},  // R5 in place
    '{3'd1, 12'h010, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0, 1'b1, 3'd0, 1'b0, 12'h000, 4'd3},  // R3 write set vs read snoop
    '{3'd0, 12'h011, 1'b0, 1'b1, 2'd0, 2'd1, 1'b0, 1'b0, 3'd0, 1'b0, 12'h000, 4'd2},  // R2 spec load on fill
    '{3'd1, 12'h011, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 3'd0, 1'b0, 12'h000, 4'd6},  // R6 read vs read
    '{3'd2, 12'h011, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0, 1'b1, 3'd1, 1'b0, 12'h000, 4'd2},  // R2 read set vs write snoop
    '{3'd0, 12'h018, 1'b0, 1'b0, 2'd0, 2'd1, 1'b0, 1'b0, 3'd0, 1'b0, 12'h000, 4'd10}, // R10 second way
    '{3'd0, 12'h020, 1'b0, 1'b0, 2'd0, 2'd0, 1'b1, 1'b0, 3'd0, 1'b0, 12'h000, 4'd9},  // R9 spec victim
    '{3'd3, 12'h000, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 3'd0, 1'b0, 12'h000, 4'd7},  // R7 commit
    '{3'd1, 12'h010, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 3'd0, 1'b0, 12'h000, 4'd7},  // R7 write flag gone
    '{3'd2, 12'h011, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 3'd0, 1'b0, 12'h000, 4'd7},  // R7 read flag gone
    '{3'd0, 12'h020, 1'b0, 1'b0, 2'd1, 2'd1, 1'b0, 1'b0, 3'd0, 1'b0, 12'h010, 4'd10}, // R10 dirty victim wb
    '{3'd0, 12'h018, 1'b1, 1'b1, 2'd0, 2'd0, 1'b0, 1'b0, 3'd0, 1'b0, 12'h000, 4'd3},  // R3 spec store clean hit
    '{3'd0, 12'h020, 1'b0, 1'b1, 2'd0, 2'd0, 1'b0, 1'b0, 3'd0, 1'b0, 12'h000, 4'd2},  // R2 spec load hit
    '{3'd4, 12'h000, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 3'd0, 1'b0, 12'h000, 4'd8},  // R8 abort
    '{3'd1, 12'h018, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 3'd0, 1'b0, 12'h000, 4'd8},  // R8 dropped line
    '{3'd0, 12'h018, 1'b0, 1'b0, 2'd0, 2'd1, 1'b0, 1'b0, 3'd0, 1'b0, 12'h000, 4'd8},  // R8 refetch, no wb
    '{3'd0, 12'h020, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 3'd0, 1'b0, 12'h000, 4'd8},  // R8 read-set line kept
    '{3'd2, 12'h020, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 3'd0, 1'b0, 12'h000, 4'd8},  // R8 read flag cleared
    '{3'd0, 12'h033, 1'b1, 1'b1, 2'd0, 2'd1, 1'b0, 1'b0, 3'd0, 1'b0, 12'h000, 4'd3},  // R3 spec store miss
    '{3'd1, 12'h033, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0, 1'b1, 3'd3, 1'b0, 12'h000, 4'd3}   // R3 / R6 index
  };

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  task automatic do_access(input logic [11:0] a, input logic w, input logic s,
                           output int nwb, output int nfill, output bit forced,
                           output bit done, output logic [11:0] wba);
    nwb = 0; nfill = 0; forced = 0; done = 0; wba = '0;
    @(negedge clk);
    req_valid = 1; req_addr = a; req_write = w; req_spec = s;
    for (int c = 0; c < 20 && !done && !forced; c++) begin
      #2;
      if (req_done) done = 1;
      else if (force_commit) forced = 1;
      if (wb_valid) begin nwb++; wba = wb_addr; wb_ack = 1; end
      if (fill_req) begin nfill++; fill_ack = 1; end
      @(negedge clk);
      wb_ack = 0; fill_ack = 0;
    end
    req_valid = 0; req_write = 0; req_spec = 0;
  endtask

  task automatic do_snoop(input logic [11:0] a, input logic w,
                          output bit v, output int vs, output int vw);
    @(negedge clk);
    snp_valid = 1; snp_addr = a; snp_write = w;
    #2;
    v = violation; vs = viol_set; vw = viol_way;
    @(negedge clk);
    snp_valid = 0; snp_write = 0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    vec_t v;
    string rq;
    int nwb, nfill, vs, vw;
    bit forced, done, vb;
    logic [11:0] wba;

    repeat (3) @(negedge clk);
    rst_ni = 1;
    #2;
    // R1 idle outputs after reset
    check(!req_done && !force_commit && !wb_valid && !fill_req, "R1", "idle outputs",
          {req_done, force_commit, wb_valid, fill_req}, 0);
    do_snoop(12'h010, 1'b1, vb, vs, vw);
    check(vb == 0, "R1", "snoop on empty cache", vb, 0);

    for (int i = 0; i < NV; i++) begin
      v = VECS[i];
      rq = $sformatf("R%0d", v.req);
      case (v.kind)
        3'd0: begin
          do_access(v.addr, v.wr, v.spec, nwb, nfill, forced, done, wba);
          check(done == !v.e_force, rq, $sformatf("vec %0d done", i), done, !v.e_force);
          check(forced == v.e_force, rq, $sformatf("vec %0d force", i), forced, v.e_force);
          check(nwb == v.e_wb, rq, $sformatf("vec %0d writebacks", i), nwb, v.e_wb);
          check(nfill == v.e_fill, rq, $sformatf("vec %0d fills", i), nfill, v.e_fill);
          if (v.e_wb != 0) check(wba == v.e_wba, rq, $sformatf("vec %0d wb addr", i), wba, v.e_wba);
        end
        3'd1, 3'd2: begin
          do_snoop(v.addr, v.kind == 3'd2, vb, vs, vw);
          check(vb == v.e_viol, rq, $sformatf("vec %0d violation", i), vb, v.e_viol);
          if (v.e_viol) begin
            check(vs == v.e_set, rq, $sformatf("vec %0d set", i), vs, v.e_set);
            check(vw == v.e_way, rq, $sformatf("vec %0d way", i), vw, v.e_way);
          end
        end
        3'd3: begin @(negedge clk); commit = 1; @(negedge clk); commit = 0; end
        default: begin @(negedge clk); abort = 1; @(negedge clk); abort = 0; end
      endcase
    end

    // R11 commit beats a hitting request in the same cycle
    @(negedge clk);
    req_valid = 1; req_addr = 12'h020; req_write = 0; req_spec = 0; commit = 1;
    #2 check(req_done == 0, "R11", "done with commit", req_done, 0);
    @(negedge clk); commit = 0;
    #2 check(req_done == 1, "R11", "done after commit", req_done, 1);
    @(negedge clk); abort = 1;
    #2 check(req_done == 0, "R11", "done with abort", req_done, 0);
    @(negedge clk); abort = 0; req_valid = 0;

    // R5 store to write-set line completes in its first cycle
    do_access(12'h033, 1'b1, 1'b1, nwb, nfill, forced, done, wba);
    @(negedge clk);
    req_valid = 1; req_addr = 12'h033; req_write = 1; req_spec = 1;
    #2 check(req_done == 1 && !wb_valid && !fill_req, "R5", "same-cycle done", req_done, 1);
    @(negedge clk); req_valid = 0; req_write = 0; req_spec = 0;

    finish_run();
  end
endmodule